// File: doc/BRIEF.md
# Soft-In Soft-Out MAP Component Decoder (8-state, log domain)

This block decodes one frame of an 8-state recursive systematic convolutional code with the forward-backward maximum a-posteriori method. It keeps all metrics in the log domain. The host first writes soft values into the block's input store, one position at a time. Each position holds a systematic value, a parity value and an a-priori value. The host then pulses `start` with the frame length. The block runs three passes over the frame:

1. A branch-metric pass fills a branch-metric store.
2. A forward pass computes the forward state metrics and keeps them.
3. A backward pass computes the backward state metrics and emits one result per position.

Results come out in descending position order. Each result carries the a-posteriori LLR, the extrinsic value and a hard decision. All soft values are two's-complement with FRAC fractional bits. A positive LLR favours a data bit of 1.

The block is meant to be one of the two component decoders inside an iterative turbo receiver. The surrounding logic owns interleaving and decides when iterations stop.

Top module: `mapSisoDecoder`

## Requirements
- R1: A cycle with `loadEn` high stores `loadSys`, `loadPar` and `loadApr` at position `loadAddr`. The stored values persist until that same position is written again. A `start` pulse while idle with `frameLen` = L (1..DEPTH) decodes positions 0..L-1.
- R2: The state is the 3-bit value {s1,s2,s3}, with s1 as bit 2. For input u, the feedback bit is a = u^s2^s3 and the parity bit is p = a^s1^s3. The next state is {a,s1,s2}.
- R3: The branch metric of a transition with input u and parity p is u·(Ls+La) + p·Lp. Here u and p are 0/1, and Ls, Lp and La are the stored systematic, parity and a-priori values of that position.
- R4: Two metrics are combined as max*(x,y) = max(x,y) + c, where d = |x−y|. The correction c is 2^(FRAC−1) for d < 2^FRAC, 2^(FRAC−2) for d < 2^(FRAC+1), and 0 otherwise.
- R5: The forward metrics start at 0 for state 0 and −2^(MW−3) for every other state. Each step combines both incoming transitions of a state with max*. Each step then subtracts the new state-0 metric from all eight states.
- R6: The backward metrics start at 0 for all states after the last position. Each step combines both outgoing transitions of a state with max*. Each step is renormalised by subtracting the state-0 metric.
- R7: For each input value, a term is formed per source state as forward metric + branch metric + backward metric of the destination. Each input value's eight terms are reduced with max* in a fixed tree: pairs (0,1), (2,3), (4,5), (6,7), then pairs of those results, then the final pair. The LLR is the input-1 result minus the input-0 result.
- R8: The extrinsic output equals LLR − Ls − La.
- R9: The hard decision is 1 exactly when the LLR is 0 or greater.
- R10: For a frame of length L, `outValid` first rises 2L+1 clock edges after the edge that accepts `start`. It then stays high for L consecutive cycles, and `outIdx` runs from L−1 down to 0.
- R11: After reset `busy` and `outValid` are low. `busy` is high from the edge that accepts `start` until the final result appears. That final result has `outLast` high and `outIdx` 0, and `busy` is low in the same cycle.
- R12: For a noiseless codeword with large equal-magnitude systematic and parity values and zero a-priori values, the hard decisions reproduce the encoded bits. The codeword is encoded by R2 from state 0 and left unterminated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| loadEn | input | 1 | Write strobe for the input store |
| loadAddr | input | AW | Position being written |
| loadSys | input | IW | Systematic soft value |
| loadPar | input | IW | Parity soft value |
| loadApr | input | IW | A-priori soft value |
| start | input | 1 | Starts decoding when idle |
| frameLen | input | LW | Frame length, 1..DEPTH |
| busy | output | 1 | Decode in progress |
| outValid | output | 1 | Result valid this cycle |
| outIdx | output | AW | Position of the current result |
| outLlr | output | MW+2 | A-posteriori LLR |
| outExt | output | MW+2 | Extrinsic value |
| outBit | output | 1 | Hard decision |
| outLast | output | 1 | Marks the result for position 0 |

## Verification
The bench uses the default parameters: DEPTH=64, IW=6, MW=12 and FRAC=2. These widths let random inputs span the full 6-bit range without metric wrap. Frame lengths therefore cover the single-position frame, full-depth frames and several lengths in between. FRAC=2 makes both correction steps of max* reachable with small differences. The all-zero frame drives every comparison into the equal-metric case and gives an LLR of exactly zero. A noiseless encoded frame checks decisions against the transmitted bits rather than against the bench model.

// File: rtl/mapDecPkg.sv
package mapDecPkg;

  localparam int NSTATE = 8;

  typedef struct packed {
    logic gamWr;
    logic fwdInit;
    logic fwdStep;
    logic bwdInit;
    logic bwdStep;
    logic lastStep;
  } ctlStrobes_t;

  // feedback bit for state {s1,s2,s3} under input u
  function automatic logic trFeed(input logic [2:0] st, input logic u);
    return u ^ st[1] ^ st[0];
  endfunction

  function automatic logic [2:0] trNext(input logic [2:0] st, input logic u);
    return {trFeed(st, u), st[2], st[1]};
  endfunction

  function automatic logic trPar(input logic [2:0] st, input logic u);
    return trFeed(st, u) ^ st[2] ^ st[0];
  endfunction

endpackage

// File: rtl/mapMaxStar.sv
module mapMaxStar #(
  parameter int W    = 14,
  parameter int FRAC = 2
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  localparam logic [W:0]          NEAR  = (W+1)'(1 << FRAC);
  localparam logic [W:0]          MID   = (W+1)'(2 << FRAC);
  localparam logic signed [W-1:0] CNEAR = W'(1 << (FRAC-1));
  localparam logic signed [W-1:0] CMID  = W'(1 << (FRAC-2));

  logic signed [W:0]   diff;
  logic [W:0]          mag;
  logic signed [W-1:0] big;
  logic signed [W-1:0] corr;

  always_comb begin
    diff = {a[W-1], a} - {b[W-1], b};
    big  = diff[W] ? b : a;
    mag  = diff[W] ? unsigned'(-diff) : unsigned'(diff);
    if (mag < NEAR)     corr = CNEAR;
    else if (mag < MID) corr = CMID;
    else                corr = '0;
    y = big + corr;
  end
endmodule

// File: rtl/mapControl.sv
module mapControl
  import mapDecPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [LW-1:0] frameLen,
  output ctlStrobes_t   ctl,
  output logic [AW-1:0] stepIdx,
  output logic          busy
);
  typedef enum logic [1:0] {PH_IDLE, PH_GAM, PH_FWD, PH_BWD} phase_t;

  phase_t        phase;
  logic [AW-1:0] lastIdx;
  logic          accept;
  logic          atEnd;

  assign accept  = (phase == PH_IDLE) && start && (frameLen != '0);
  assign atEnd   = (stepIdx == lastIdx);
  assign busy    = (phase != PH_IDLE);

  always_comb begin
    ctl          = '0;
    ctl.fwdInit  = accept;
    ctl.gamWr    = (phase == PH_GAM);
    ctl.fwdStep  = (phase == PH_FWD);
    ctl.bwdInit  = (phase == PH_FWD) && atEnd;
    ctl.bwdStep  = (phase == PH_BWD);
    ctl.lastStep = (phase == PH_BWD) && (stepIdx == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      stepIdx <= '0;
      lastIdx <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) begin
          lastIdx <= AW'(frameLen - LW'(1));
          stepIdx <= '0;
          phase   <= PH_GAM;
        end
        PH_GAM: begin
          if (atEnd) begin
            stepIdx <= '0;
            phase   <= PH_FWD;
          end else begin
            stepIdx <= stepIdx + AW'(1);
          end
        end
        PH_FWD: begin
          if (atEnd) phase <= PH_BWD;
          else       stepIdx <= stepIdx + AW'(1);
        end
        PH_BWD: begin
          if (stepIdx == '0) phase <= PH_IDLE;
          else               stepIdx <= stepIdx - AW'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mapDatapath.sv
module mapDatapath
  import mapDecPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IW    = 6,
  parameter int MW    = 12,
  parameter int FRAC  = 2,
  parameter int AW    = $clog2(DEPTH),
  parameter int SW    = MW + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadEn,
  input  logic [AW-1:0]        loadAddr,
  input  logic signed [IW-1:0] loadSys,
  input  logic signed [IW-1:0] loadPar,
  input  logic signed [IW-1:0] loadApr,
  input  ctlStrobes_t          ctl,
  input  logic [AW-1:0]        stepIdx,
  output logic                 outValid,
  output logic [AW-1:0]        outIdx,
  output logic signed [SW-1:0] outLlr,
  output logic signed [SW-1:0] outExt,
  output logic                 outBit,
  output logic                 outLast
);
  localparam int GW = IW + 2;
  localparam logic signed [MW-1:0] ALPHA_FLOOR = -MW'(1 << (MW-3));

  // input store
  logic signed [IW-1:0] sysMem [DEPTH];
  logic signed [IW-1:0] parMem [DEPTH];
  logic signed [IW-1:0] aprMem [DEPTH];
  // branch-metric store: index {u,p}; {0,0} is always zero
  logic signed [GW-1:0] g01Mem [DEPTH];
  logic signed [GW-1:0] g10Mem [DEPTH];
  logic signed [GW-1:0] g11Mem [DEPTH];
  // forward metric store
  logic signed [MW-1:0] alphaMem [DEPTH][NSTATE];

  logic signed [MW-1:0] alphaReg [NSTATE];
  logic signed [MW-1:0] betaReg  [NSTATE];
  logic signed [GW-1:0] gCur     [4];
  logic signed [SW-1:0] fwdRaw   [NSTATE];
  logic signed [SW-1:0] bwdRaw   [NSTATE];
  logic signed [SW-1:0] term     [2][NSTATE];
  logic signed [SW-1:0] lvA      [2][4];
  logic signed [SW-1:0] lvB      [2][2];
  logic signed [SW-1:0] lvC      [2];
  logic signed [SW-1:0] llrVal;
  logic signed [GW-1:0] lsaNow;

  assign gCur[0] = '0;
  assign gCur[1] = g01Mem[stepIdx];
  assign gCur[2] = g10Mem[stepIdx];
  assign gCur[3] = g11Mem[stepIdx];
  assign lsaNow  = GW'(sysMem[stepIdx]) + GW'(aprMem[stepIdx]);

  always_ff @(posedge clk) begin
    if (loadEn) begin
      sysMem[loadAddr] <= loadSys;
      parMem[loadAddr] <= loadPar;
      aprMem[loadAddr] <= loadApr;
    end
    if (ctl.gamWr) begin
      g01Mem[stepIdx] <= GW'(parMem[stepIdx]);
      g10Mem[stepIdx] <= lsaNow;
      g11Mem[stepIdx] <= lsaNow + GW'(parMem[stepIdx]);
    end
    if (ctl.fwdStep) begin
      for (int s = 0; s < NSTATE; s++) alphaMem[stepIdx][s] <= alphaReg[s];
    end
  end

  // forward add-compare-select: state n is entered from {n[1:0],x}
  for (genvar n = 0; n < NSTATE; n++) begin : gFwd
    localparam int PRED0 = (n & 3) << 1;
    localparam int GI0   = ((((n >> 2) ^ n) & 1) << 1) | (((n >> 2) ^ (n >> 1)) & 1);
    localparam int GI1   = 3 - GI0;
    logic signed [SW-1:0] candA, candB;
    assign candA = SW'(alphaReg[PRED0])     + SW'(gCur[GI0]);
    assign candB = SW'(alphaReg[PRED0 + 1]) + SW'(gCur[GI1]);
    mapMaxStar #(.W(SW), .FRAC(FRAC)) uAcs (.a(candA), .b(candB), .y(fwdRaw[n]));
  end

  // backward add-compare-select and per-transition LLR terms
  for (genvar s = 0; s < NSTATE; s++) begin : gBwd
    localparam int NX0 = int'(trNext(3'(s), 1'b0));
    localparam int NX1 = int'(trNext(3'(s), 1'b1));
    localparam int GI0 = int'(trPar(3'(s), 1'b0));
    localparam int GI1 = 2 | int'(trPar(3'(s), 1'b1));
    logic signed [SW-1:0] candA, candB;
    assign candA = SW'(betaReg[NX0]) + SW'(gCur[GI0]);
    assign candB = SW'(betaReg[NX1]) + SW'(gCur[GI1]);
    mapMaxStar #(.W(SW), .FRAC(FRAC)) uAcs (.a(candA), .b(candB), .y(bwdRaw[s]));
    assign term[0][s] = SW'(alphaMem[stepIdx][s]) + candA;
    assign term[1][s] = SW'(alphaMem[stepIdx][s]) + candB;
  end

  // fixed max* reduction tree per input value
  for (genvar u = 0; u < 2; u++) begin : gTree
    for (genvar i = 0; i < 4; i++) begin : gLa
      mapMaxStar #(.W(SW), .FRAC(FRAC)) uM (.a(term[u][2*i]), .b(term[u][2*i+1]), .y(lvA[u][i]));
    end
    for (genvar i = 0; i < 2; i++) begin : gLb
      mapMaxStar #(.W(SW), .FRAC(FRAC)) uM (.a(lvA[u][2*i]), .b(lvA[u][2*i+1]), .y(lvB[u][i]));
    end
    mapMaxStar #(.W(SW), .FRAC(FRAC)) uM (.a(lvB[u][0]), .b(lvB[u][1]), .y(lvC[u]));
  end

  assign llrVal = lvC[1] - lvC[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NSTATE; s++) begin
        alphaReg[s] <= '0;
        betaReg[s]  <= '0;
      end
      outValid <= 1'b0;
      outIdx   <= '0;
      outLlr   <= '0;
      outExt   <= '0;
      outBit   <= 1'b0;
      outLast  <= 1'b0;
    end else begin
      if (ctl.fwdInit) begin
        for (int s = 0; s < NSTATE; s++) alphaReg[s] <= (s == 0) ? '0 : ALPHA_FLOOR;
      end else if (ctl.fwdStep) begin
        for (int s = 0; s < NSTATE; s++) alphaReg[s] <= MW'(fwdRaw[s] - fwdRaw[0]);
      end
      if (ctl.bwdInit) begin
        for (int s = 0; s < NSTATE; s++) betaReg[s] <= '0;
      end else if (ctl.bwdStep) begin
        for (int s = 0; s < NSTATE; s++) betaReg[s] <= MW'(bwdRaw[s] - bwdRaw[0]);
      end
      outValid <= ctl.bwdStep;
      outLast  <= ctl.lastStep;
      if (ctl.bwdStep) begin
        outIdx <= stepIdx;
        outLlr <= llrVal;
        outExt <= llrVal - SW'(sysMem[stepIdx]) - SW'(aprMem[stepIdx]);
        outBit <= ~llrVal[SW-1];
      end
    end
  end
endmodule

// File: rtl/mapSisoDecoder.sv
module mapSisoDecoder
  import mapDecPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IW    = 6,
  parameter int MW    = 12,
  parameter int FRAC  = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH+1),
  localparam int SW   = MW + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadEn,
  input  logic [AW-1:0]        loadAddr,
  input  logic signed [IW-1:0] loadSys,
  input  logic signed [IW-1:0] loadPar,
  input  logic signed [IW-1:0] loadApr,
  input  logic                 start,
  input  logic [LW-1:0]        frameLen,
  output logic                 busy,
  output logic                 outValid,
  output logic [AW-1:0]        outIdx,
  output logic signed [SW-1:0] outLlr,
  output logic signed [SW-1:0] outExt,
  output logic                 outBit,
  output logic                 outLast
);
  ctlStrobes_t   ctl;
  logic [AW-1:0] stepIdx;

  mapControl #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) uCtl (
    .clk(clk), .rstN(rstN), .start(start), .frameLen(frameLen),
    .ctl(ctl), .stepIdx(stepIdx), .busy(busy)
  );

  mapDatapath #(.DEPTH(DEPTH), .IW(IW), .MW(MW), .FRAC(FRAC), .AW(AW), .SW(SW)) uDp (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadSys(loadSys), .loadPar(loadPar), .loadApr(loadApr),
    .ctl(ctl), .stepIdx(stepIdx),
    .outValid(outValid), .outIdx(outIdx), .outLlr(outLlr), .outExt(outExt),
    .outBit(outBit), .outLast(outLast)
  );
endmodule

// File: rtl/mapSisoChecker.sv
module mapSisoChecker #(
  parameter int AW = 6,
  parameter int SW = 14
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busy,
  input logic                 outValid,
  input logic [AW-1:0]        outIdx,
  input logic signed [SW-1:0] outLlr,
  input logic                 outBit,
  input logic                 outLast
);
  a_r10_idx_descend: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(outValid) |-> outIdx == $past(outIdx) - AW'(1));

  a_r10_run_ends_last: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> $past(outLast));

  a_r9_slicer: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outBit == (outLlr >= 0)));

  a_r11_last_idle: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outLast |-> !busy && outIdx == '0);

  a_r11_busy_during_run: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outLast |-> busy);
endmodule

bind mapSisoDecoder mapSisoChecker #(.AW(AW), .SW(SW)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .outValid(outValid), .outIdx(outIdx),
  .outLlr(outLlr), .outBit(outBit), .outLast(outLast)
);

// File: tb/sim_mapSisoDecoder.sv
module sim_mapSisoDecoder;
  localparam int DEPTH = 64, IW = 6, MW = 12, FRAC = 2;
  localparam int AW = $clog2(DEPTH), LW = $clog2(DEPTH+1), SW = MW + 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic loadEn = 1'b0, start = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic signed [IW-1:0] loadSys = '0, loadPar = '0, loadApr = '0;
  logic [LW-1:0] frameLen = '0;
  logic busy, outValid, outBit, outLast;
  logic [AW-1:0] outIdx;
  logic signed [SW-1:0] outLlr, outExt;

  always #4 clk = ~clk;

  mapSisoDecoder #(.DEPTH(DEPTH), .IW(IW), .MW(MW), .FRAC(FRAC)) u0 (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  int vSys[DEPTH], vPar[DEPTH], vApr[DEPTH];
  int refLlr[DEPTH], refExt[DEPTH];
  int gotBit[DEPTH];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nxt(int s, int u);
    int a = (u ^ (s >> 1) ^ s) & 1;
    return (a << 2) | (s >> 1);
  endfunction
  function automatic int par(int s, int u);
    int a = (u ^ (s >> 1) ^ s) & 1;
    return (a ^ (s >> 2) ^ s) & 1;
  endfunction
  function automatic int mstar(int a, int b);
    int d = (a > b) ? a - b : b - a;
    int c = (d < (1 << FRAC)) ? (1 << (FRAC-1)) : (d < (2 << FRAC)) ? (1 << (FRAC-2)) : 0;
    return ((a > b) ? a : b) + c;
  endfunction

  task automatic computeRef(input int L);
    int al[DEPTH+1][8];
    int be[8], nb[8], raw[8], t[2][8], lv[8];
    bit seen[8];
    for (int s = 0; s < 8; s++) al[0][s] = (s == 0) ? 0 : -(1 << (MW-3));
    for (int k = 0; k < L; k++) begin
      for (int n = 0; n < 8; n++) seen[n] = 0;
      for (int s = 0; s < 8; s++)
        for (int u = 0; u < 2; u++) begin
          int n = nxt(s, u);
          int v = al[k][s] + u * (vSys[k] + vApr[k]) + par(s, u) * vPar[k];
          raw[n] = seen[n] ? mstar(raw[n], v) : v;
          seen[n] = 1;
        end
      for (int n = 0; n < 8; n++) al[k+1][n] = raw[n] - raw[0];
    end
    for (int s = 0; s < 8; s++) be[s] = 0;
    for (int k = L - 1; k >= 0; k--) begin
      for (int s = 0; s < 8; s++)
        for (int u = 0; u < 2; u++)
          t[u][s] = al[k][s] + u * (vSys[k] + vApr[k]) + par(s, u) * vPar[k] + be[nxt(s, u)];
      for (int u = 0; u < 2; u++) begin
        for (int i = 0; i < 4; i++) lv[i] = mstar(t[u][2*i], t[u][2*i+1]);
        lv[4 + u] = mstar(mstar(lv[0], lv[1]), mstar(lv[2], lv[3]));
      end
      refLlr[k] = lv[5] - lv[4];
      refExt[k] = refLlr[k] - vSys[k] - vApr[k];
      for (int s = 0; s < 8; s++)
        nb[s] = mstar(t[0][s] - al[k][s], t[1][s] - al[k][s]);
      for (int s = 0; s < 8; s++) be[s] = nb[s] - nb[0];
    end
  endtask

  task automatic writePos(input int i);
    @(negedge clk);
    loadEn = 1; loadAddr = AW'(i);
    loadSys = IW'(vSys[i]); loadPar = IW'(vPar[i]); loadApr = IW'(vApr[i]);
    @(negedge clk);
    loadEn = 0;
  endtask

  task automatic loadFrame(input int L);
    for (int i = 0; i < L; i++) writePos(i);
  endtask

  function automatic int rnd();
    return int'($urandom_range(63)) - 32;
  endfunction

  task automatic runFrame(input int L);
    int cyc = 0, got = 0;
    computeRef(L);
    @(negedge clk);
    frameLen = LW'(L); start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R11 busy after start", int'(busy), 1);
    while (got < L && cyc < 4 * L + 16) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (outValid) begin
        int idx = L - 1 - got;
        if (got == 0) chk(cyc == 2 * L + 1, "R10 first result latency", cyc, 2 * L + 1);
        chk(int'(outIdx) == idx, "R10 index order", int'(outIdx), idx);
        chk(int'(outLlr) == refLlr[idx], "R3 R4 R5 R6 R7 llr", int'(outLlr), refLlr[idx]);
        chk(int'(outExt) == refExt[idx], "R8 extrinsic", int'(outExt), refExt[idx]);
        chk(int'(outBit) == int'(refLlr[idx] >= 0), "R9 hard decision", int'(outBit), int'(refLlr[idx] >= 0));
        gotBit[idx] = int'(outBit);
        if (got == L - 1) begin
          chk(outLast == 1'b1, "R11 last marker", int'(outLast), 1);
          chk(busy == 1'b0, "R11 busy low at last result", int'(busy), 0);
        end
        got++;
      end
    end
    chk(got == L, "R10 result count", got, L);
    @(negedge clk);
    chk(outValid == 1'b0, "R10 valid drops after run", int'(outValid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int bits[DEPTH];
    int st;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R11 reset busy", int'(busy), 0);
    chk(outValid == 1'b0, "R11 reset valid", int'(outValid), 0);
    rstN = 1;

    // R1 single position, all zeros: LLR exactly zero, decision 1 (R9)
    vSys[0] = 0; vPar[0] = 0; vApr[0] = 0;
    loadFrame(1);
    runFrame(1);
    chk(gotBit[0] == 1, "R9 zero llr gives one", gotBit[0], 1);

    // all-zero full-depth frame
    for (int i = 0; i < DEPTH; i++) begin vSys[i] = 0; vPar[i] = 0; vApr[i] = 0; end
    loadFrame(DEPTH);
    runFrame(DEPTH);

    // random full-range frames of several lengths, including full depth
    foreach (bits[i]) bits[i] = 0;
    for (int f = 0; f < 6; f++) begin
      int L = (f == 0) ? DEPTH : (f == 1) ? 2 : int'($urandom_range(DEPTH - 1, 3));
      for (int i = 0; i < L; i++) begin vSys[i] = rnd(); vPar[i] = rnd(); vApr[i] = rnd(); end
      loadFrame(L);
      runFrame(L);
      if (f == 0) begin
        // R1: rewrite only position 5; the rest must persist
        vSys[5] = 31; vPar[5] = -32; vApr[5] = 17;
        writePos(5);
        runFrame(L);
      end
    end

    // strong negative a-priori only: every decision is 0
    for (int i = 0; i < 20; i++) begin vSys[i] = 0; vPar[i] = 0; vApr[i] = -32; end
    loadFrame(20);
    runFrame(20);
    for (int i = 0; i < 20; i++) chk(gotBit[i] == 0, "R9 negative prior gives zero", gotBit[i], 0);

    // R12 / R2: noiseless unterminated codeword
    st = 0;
    for (int i = 0; i < 40; i++) begin
      bits[i] = int'($urandom_range(1));
      vSys[i] = bits[i] ? 12 : -12;
      vPar[i] = par(st, bits[i]) ? 12 : -12;
      vApr[i] = 0;
      st = nxt(st, bits[i]);
    end
    loadFrame(40);
    runFrame(40);
    for (int i = 0; i < 40; i++) chk(gotBit[i] == bits[i], "R12 R2 codeword bit", gotBit[i], bits[i]);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule